// File: doc/BRIEF.md
# Receive Packet Buffer with Abort Rollback

This block is a single-clock packet buffer placed between a network receive path and a 32-bit host read port. The receive side pushes one double word per cycle, tagging the first word of each frame with a start marker and the last with an end-of-frame marker. The host side sees words in arrival order, each shown together with its stored end-of-frame bit, in show-ahead form: the head word is visible whenever the buffer is not empty, and a read strobe moves on to the next word.

Only whole frames ever reach the host. The buffer keeps two write positions. The live position follows every accepted word. The committed position moves forward only when a frame's last word is written. The host compares its read position against the committed one. An abort request, or a write attempt that finds the buffer full, moves the live position back to the committed one. The receive side is then locked out until a word carrying the start marker arrives. Frames that finished earlier stay in the buffer and remain readable.

Top module: `pkt_abort_fifo`

## Requirements
- R1: Words come out in the order they were written, each with its own 32-bit data and the end-of-frame bit it had when written; `rd_data`/`rd_eof` show the head word whenever `rd_empty` is 0, and a cycle with `rd_en` high moves to the next word.
- R2: Words of a frame stay invisible to the reader (`rd_empty` stays 1 if nothing else is committed) until the word with `wr_eof`=1 is written; from the clock edge that writes it, the whole frame is readable.
- R3: A cycle with `abort`=1 discards every word of the unfinished frame, while frames already completed stay readable and intact.
- R4: After an abort or a dropped write, words with `wr_sop`=0 are ignored; the first word with `wr_sop`=1 is accepted and ends the lockout.
- R5: When `abort` and a write carrying `wr_eof`=1 fall in the same cycle, the abort wins: the word is not stored and nothing is committed.
- R6: `full` is 1 exactly when the written words (committed plus unfinished) fill all DEPTH entries, and 0 otherwise.
- R7: A write attempted while `full` is 1 is dropped, and the unfinished frame is discarded as in R3, so a truncated frame is never committed.
- R8: `rd_en` while `rd_empty` is 1 has no effect on the stored words or the read order.
- R9: After reset `rd_empty` is 1, `full` is 0 and the receive side is not locked out.
- R10: DEPTH is a power of two, and the storage wraps freely: frames of any length from 1 to DEPTH, written back to back over many wraps, are read back correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A receive word is offered this cycle |
| wr_sop | input | 1 | Offered word is the first of a frame |
| wr_eof | input | 1 | Offered word is the last of a frame |
| wr_data | input | 32 | Receive data word |
| abort | input | 1 | Discard the unfinished frame and lock out input until the next start |
| rd_en | input | 1 | Host consumes the head word |
| rd_data | output | 32 | Head word data |
| rd_eof | output | 1 | Head word end-of-frame bit |
| rd_empty | output | 1 | No committed word is available |
| full | output | 1 | Every entry is taken by written words |

## Verification
Frames of every length from one word to the full depth are written and read back twice over, with data derived from the frame length and word index. This shows that ordering, end-of-frame bits and pointer wrap are right at every fill level, and that `full` rises only at the exact depth. Separate sequences send aborts in the middle of a frame, at the same cycle as an end-of-frame word, and after completed frames. The follow-up words without a start marker tell a working lockout apart from one that leaks. A frame that overruns the buffer behind a completed one shows that the overflow drops only the truncated frame. Reads on an empty buffer followed by a fresh frame show that such reads leave no trace.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

  // Distance from read pointer to write pointer, modulo twice the depth.
  function automatic logic [31:0] ring_used(input logic [31:0] wp,
                                            input logic [31:0] rp,
                                            input int unsigned aw);
    logic [31:0] mask;
    mask = (32'd1 << (aw + 1)) - 32'd1;
    return (wp - rp) & mask;
  endfunction

  function automatic logic ring_full(input logic [31:0] wp,
                                     input logic [31:0] rp,
                                     input int unsigned aw,
                                     input int unsigned depth);
    return ring_used(wp, rp, aw) == depth;
  endfunction

endpackage

// File: rtl/pkt_fifo_mem.sv
module pkt_fifo_mem #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 33,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/pkt_fifo_wrctl.sv
module pkt_fifo_wrctl
  import pkt_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          wr_sop,
  input  logic          wr_eof,
  input  logic          abort,
  input  logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] live_ptr,
  output logic [PW-1:0] commit_ptr,
  output logic          full,
  output logic          locked,
  output logic          wr_accept,
  output logic          wr_commit,
  output logic          wr_drop
);

  logic eligible;

  assign full      = ring_full(32'(live_ptr), 32'(rd_ptr), AW, DEPTH);
  assign eligible  = wr_valid && (!locked || wr_sop);
  assign wr_drop   = eligible && !abort && full;
  assign wr_accept = eligible && !abort && !full;
  assign wr_commit = wr_accept && wr_eof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_ptr   <= '0;
      commit_ptr <= '0;
      locked     <= 1'b0;
    end else if (abort || wr_drop) begin
      live_ptr <= commit_ptr;
      locked   <= 1'b1;
    end else if (wr_accept) begin
      live_ptr <= live_ptr + 1'b1;
      locked   <= 1'b0;
      if (wr_eof) commit_ptr <= live_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/pkt_fifo_rdctl.sv
module pkt_fifo_rdctl #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] commit_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          rd_empty,
  output logic          rd_pop
);

  assign rd_empty = (rd_ptr == commit_ptr);
  assign rd_pop   = rd_en && !rd_empty;

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_ptr <= '0;
    else if (rd_pop) rd_ptr <= rd_ptr + 1'b1;
  end

endmodule

// File: rtl/pkt_abort_fifo.sv
module pkt_abort_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_sop,
  input  logic              wr_eof,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              abort,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_eof,
  output logic              rd_empty,
  output logic              full
);

  logic [PW-1:0] live_ptr;
  logic [PW-1:0] commit_ptr;
  logic [PW-1:0] rd_ptr;
  logic          locked;
  logic          wr_accept;
  logic          wr_commit;
  logic          wr_drop;
  logic          rd_pop;
  logic [DATA_W:0] head_word;

  pkt_fifo_wrctl #(.DEPTH(DEPTH)) u_wrctl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sop(wr_sop),
    .wr_eof(wr_eof), .abort(abort), .rd_ptr(rd_ptr), .live_ptr(live_ptr),
    .commit_ptr(commit_ptr), .full(full), .locked(locked),
    .wr_accept(wr_accept), .wr_commit(wr_commit), .wr_drop(wr_drop)
  );

  pkt_fifo_rdctl #(.DEPTH(DEPTH)) u_rdctl (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .commit_ptr(commit_ptr),
    .rd_ptr(rd_ptr), .rd_empty(rd_empty), .rd_pop(rd_pop)
  );

  pkt_fifo_mem #(.DEPTH(DEPTH), .WIDTH(DATA_W + 1)) u_mem (
    .clk(clk), .we(wr_accept), .waddr(live_ptr[AW-1:0]),
    .wdata({wr_eof, wr_data}), .raddr(rd_ptr[AW-1:0]), .rdata(head_word)
  );

  assign rd_data = head_word[DATA_W-1:0];
  assign rd_eof  = head_word[DATA_W];

endmodule

// File: rtl/pkt_abort_fifo_chk.sv
module pkt_abort_fifo_chk
  import pkt_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_sop,
  input logic          abort,
  input logic          rd_en,
  input logic          rd_empty,
  input logic          full,
  input logic [PW-1:0] live_ptr,
  input logic [PW-1:0] commit_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          locked,
  input logic          wr_accept,
  input logic          wr_commit,
  input logic          wr_drop
);

  AST_EOF_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> commit_ptr == live_ptr); // R2
  AST_NO_EARLY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(commit_ptr)); // R2
  AST_ABORT_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (live_ptr == commit_ptr) && locked); // R3
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_valid && !wr_sop) |-> !wr_accept); // R4
  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !wr_commit); // R5
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_accept); // R6
  AST_DROP_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> locked && (live_ptr == commit_ptr)); // R7
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_empty && rd_en) |=> $stable(rd_ptr)); // R8
  AST_BOUNDED_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ring_used(32'(commit_ptr), 32'(rd_ptr), AW) <= DEPTH); // R10

endmodule

bind pkt_abort_fifo pkt_abort_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sop(wr_sop),
  .abort(abort), .rd_en(rd_en), .rd_empty(rd_empty), .full(full),
  .live_ptr(live_ptr), .commit_ptr(commit_ptr), .rd_ptr(rd_ptr),
  .locked(locked), .wr_accept(wr_accept), .wr_commit(wr_commit),
  .wr_drop(wr_drop)
);

// File: tb/pkt_abort_fifo_tb.sv
module pkt_abort_fifo_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_sop = 1'b0, wr_eof = 1'b0, abort = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rd_eof, rd_empty, full;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pkt_abort_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sop(wr_sop),
    .wr_eof(wr_eof), .wr_data(wr_data), .abort(abort), .rd_en(rd_en),
    .rd_data(rd_data), .rd_eof(rd_eof), .rd_empty(rd_empty), .full(full)
  );

  function automatic logic [31:0] pat(int len, int idx);
    return 32'hA500_0000 ^ (32'(len) << 12) ^ 32'(idx * 7 + 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic s, logic e, logic [31:0] d, logic a);
    @(negedge clk);
    wr_valid = v; wr_sop = s; wr_eof = e; wr_data = d; abort = a;
    @(posedge clk);
    #1;
    wr_valid = 1'b0; wr_sop = 1'b0; wr_eof = 1'b0; abort = 1'b0;
  endtask

  task automatic pop_expect(string req, logic [31:0] d, logic e);
    chk(req, {31'd0, rd_empty}, 32'd0);
    chk(req, rd_data, d);
    chk(req, {31'd0, rd_eof}, {31'd0, e});
    @(negedge clk);
    rd_en = 1'b1;
    @(posedge clk);
    #1;
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R9 reset state
    chk("R9 empty", {31'd0, rd_empty}, 32'd1);
    chk("R9 full",  {31'd0, full}, 32'd0);

    // R8 read on empty, then R9 unlocked: non-sop word accepted after reset
    @(negedge clk); rd_en = 1'b1; @(posedge clk); #1; rd_en = 1'b0;
    step(1, 0, 0, 32'h1111_0000, 0);
    chk("R2 not visible", {31'd0, rd_empty}, 32'd1);
    step(1, 0, 1, 32'h1111_0001, 0);
    chk("R2 visible after eof", {31'd0, rd_empty}, 32'd0);
    pop_expect("R8 R9 first", 32'h1111_0000, 1'b0);
    pop_expect("R1 second", 32'h1111_0001, 1'b1);
    chk("R1 drained", {31'd0, rd_empty}, 32'd1);

    // R10 sweep every frame length twice (wraps pointers)
    for (int rep = 0; rep < 2; rep++) begin
      for (int len = 1; len <= DEPTH; len++) begin
        for (int i = 0; i < len; i++)
          step(1, i == 0, i == len - 1, pat(len, i), 0);
        chk("R6 full at depth", {31'd0, full}, {31'd0, len == DEPTH});
        for (int i = 0; i < len; i++)
          pop_expect("R10 sweep", pat(len, i), i == len - 1);
        chk("R10 empty after sweep", {31'd0, rd_empty}, 32'd1);
      end
    end

    // R3/R4: complete frame, partial frame aborted, stray words ignored
    step(1, 1, 0, 32'hC000_0000, 0);
    step(1, 0, 1, 32'hC000_0001, 0);
    step(1, 1, 0, 32'hD000_0000, 0);
    step(1, 0, 0, 32'hD000_0001, 0);
    step(0, 0, 0, 32'h0, 1);
    step(1, 0, 0, 32'hE000_0000, 0);
    step(1, 0, 1, 32'hE000_0001, 0);
    step(1, 1, 1, 32'hF000_0000, 0);
    pop_expect("R3 kept frame", 32'hC000_0000, 1'b0);
    pop_expect("R3 kept frame", 32'hC000_0001, 1'b1);
    pop_expect("R4 next sop frame", 32'hF000_0000, 1'b1);
    chk("R4 stray words ignored", {31'd0, rd_empty}, 32'd1);

    // R5 abort together with eof
    step(1, 1, 0, 32'h5500_0000, 0);
    step(1, 0, 1, 32'h5500_0001, 1);
    chk("R5 abort wins", {31'd0, rd_empty}, 32'd1);
    step(1, 0, 1, 32'h5500_0002, 0);
    chk("R5 locked after", {31'd0, rd_empty}, 32'd1);
    step(1, 1, 1, 32'h5600_0000, 0);
    pop_expect("R5 recovery", 32'h5600_0000, 1'b1);

    // R6/R7 overflow behind a completed frame
    for (int i = 0; i < 3; i++) step(1, i == 0, i == 2, pat(30, i), 0);
    for (int i = 0; i < 5; i++) step(1, i == 0, 0, pat(31, i), 0);
    chk("R6 full with partial", {31'd0, full}, 32'd1);
    step(1, 0, 1, pat(31, 5), 0);
    chk("R7 dropped frees space", {31'd0, full}, 32'd0);
    step(1, 0, 1, pat(31, 6), 0);
    for (int i = 0; i < 3; i++)
      pop_expect("R7 earlier frame intact", pat(30, i), i == 2);
    chk("R7 no truncated frame", {31'd0, rd_empty}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule